// File: doc/BRIEF.md
# Prebyte-Aware Instruction Opcode Decoder

This block sits in the fetch and decode front end of a small 8-bit processor. It receives instruction bytes one at a time, each qualified by a valid strobe. It splits the stream into instructions. Each instruction is an optional modifier prefix byte, then one opcode byte, then zero, one or two operand bytes. For every opcode it reports the opcode value, an addressing-mode modifier, and the number of operand bytes that follow.

Three prefix values change how the next opcode addresses memory. The first swaps the X index register for Y. The second turns direct and X-indexed forms into their memory-indirect versions. The third turns indirect X-indexed forms into indirect Y-indexed. The block accepts one prefix per instruction. It resolves the modifier and the operand length from the opcode's addressing column, which is the upper nibble of the opcode. It then consumes exactly that many operand bytes before it looks for the next instruction.

An opcode-position byte that is not in the legal table produces a one-cycle reset request for the system. A legal prefix followed by a legal opcode that the prefix cannot modify is not an error. The prefix is dropped and the opcode decodes plainly. The legal map, the per-column lengths and the column sets for each prefix are parameters.

Top module: `pfx_op_decoder`

## Requirements
- R1: While `rst_n` is low, `dec_valid` and `trap_req` are 0. A prefix accepted before a reset is forgotten, so the first byte after reset starts a new instruction.
- R2: A legal opcode with no prefix gives `dec_valid`=1 for one cycle, on the clock edge after the byte is accepted. With it come `dec_opcode` = the byte and `dec_mod` = 0 (plain). `dec_len` comes from the column (upper nibble): 0→2, 1→1, 2→1, 3→1, 4→0, 5→0, 6→1, 7→0, 8→0, 9→0, A→1, B→1, C→2, D→2, E→1, F→0.
- R3: Prefix 0x90 followed by a legal opcode in column 5, 6, 7, D, E or F gives `dec_mod` = 1 (Y swap), with the column's plain length.
- R4: Prefix 0x92 followed by a legal opcode in column 0, 1, 3, B, C, D or E gives `dec_mod` = 2 (indirect). The length is 1 for columns C and D. For the other columns it is the plain length.
- R5: Prefix 0x91 followed by a legal opcode in column D or E gives `dec_mod` = 3 (indirect Y), with length 1.
- R6: A prefix followed by a legal opcode outside that prefix's column set decodes with `dec_mod` = 0 and the plain length. It raises no `trap_req`.
- R7: A byte is illegal in opcode position when it falls in one of these groups:
  - upper nibble 3–7 with lower nibble 1, 5 or B;
  - upper nibble 8 or 9 with lower nibble 2 or 5;
  - 0x90, 0x91 or 0xA7.

  Such a byte gives `trap_req`=1 for exactly one cycle, on the next edge, and no `dec_valid`.
- R8: A byte directly after a prefix is always treated as an opcode. A second prefix value in that slot is judged against the legal table. Under the default table it therefore traps.
- R9: After a decode with length N, the next N accepted bytes are operands. They cause neither `dec_valid` nor `trap_req`, whatever their value.
- R10: A byte presented with `in_valid`=0 is ignored. No state changes, including a pending prefix or remaining operand count.
- R11: After a trap, the decoder starts a new instruction with no pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte strobe |
| in_byte | input | 8 | Instruction byte |
| dec_valid | output | 1 | One-cycle pulse: opcode decoded |
| dec_opcode | output | 8 | Decoded opcode value |
| dec_mod | output | 2 | Modifier: 0 plain, 1 Y swap, 2 indirect, 3 indirect Y |
| dec_len | output | 2 | Operand bytes that follow the opcode |
| trap_req | output | 1 | One-cycle reset request for an illegal opcode |

## Verification
The bench runs every byte value through the opcode slot, both with no prefix and after each of the three prefixes. A decoder that confused prefix-versus-opcode priority, or mis-shortened indirect forms, would report a wrong modifier or length. Operand fill bytes are themselves illegal or prefix values. A design that mis-counted operands would trap spuriously, or would lose sync and decode operands as opcodes. Further tests cover:
- idle gaps that carry junk bytes, where a design that ignored the strobe would trap;
- a trap raised while a prefix is pending, where a stale modifier would leak into the next instruction;
- a reset that arrives while a prefix is pending.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  localparam int OPC_W  = 8;
  localparam int OPC_N  = 1 << OPC_W;
  localparam int COL_N  = 16;
  localparam int LEN_W  = 2;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'd0,
    MOD_YSWAP = 2'd1,
    MOD_IND   = 2'd2,
    MOD_INDY  = 2'd3
  } addr_mod_e;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_PRE   = 2'd1,
    ST_OPND  = 2'd2
  } dec_state_e;

  // Default legality map: bit b set means byte b is a legal opcode.
  function automatic logic [OPC_N-1:0] default_legal_map();
    logic [OPC_N-1:0] m;
    for (int i = 0; i < OPC_N; i++) begin
      logic [7:0] b;
      logic [3:0] hi;
      logic [3:0] lo;
      logic       bad;
      b  = 8'(i);
      hi = b[7:4];
      lo = b[3:0];
      bad = 1'b0;
      if (hi >= 4'h3 && hi <= 4'h7 && (lo == 4'h1 || lo == 4'h5 || lo == 4'hB))
        bad = 1'b1;
      if ((hi == 4'h8 || hi == 4'h9) && (lo == 4'h2 || lo == 4'h5))
        bad = 1'b1;
      if (b == 8'h90 || b == 8'h91 || b == 8'hA7)
        bad = 1'b1;
      m[i] = ~bad;
    end
    return m;
  endfunction

  // Default plain operand length per column, two bits per column.
  function automatic logic [COL_N*LEN_W-1:0] default_base_len();
    logic [COL_N*LEN_W-1:0] t;
    for (int c = 0; c < COL_N; c++) begin
      logic [LEN_W-1:0] n;
      case (c)
        0, 12, 13:              n = 2'd2;
        1, 2, 3, 6, 10, 11, 14: n = 2'd1;
        default:                n = 2'd0;
      endcase
      t[c*LEN_W +: LEN_W] = n;
    end
    return t;
  endfunction

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
  import pfx_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PRE_YSWAP = 8'h90,
  parameter logic [OPC_W-1:0] PRE_INDY  = 8'h91,
  parameter logic [OPC_W-1:0] PRE_IND   = 8'h92,
  parameter logic [OPC_N-1:0] LEGAL_MAP = default_legal_map()
) (
  input  logic [OPC_W-1:0] byte_i,
  output logic             is_pre_o,
  output addr_mod_e        pre_mod_o,
  output logic             legal_o
);

  localparam int NPRE = 3;

  logic [OPC_W-1:0] pre_code [NPRE];
  addr_mod_e        pre_kind [NPRE];
  logic [NPRE-1:0]  hit;

  assign pre_code[0] = PRE_YSWAP;
  assign pre_code[1] = PRE_INDY;
  assign pre_code[2] = PRE_IND;
  assign pre_kind[0] = MOD_YSWAP;
  assign pre_kind[1] = MOD_INDY;
  assign pre_kind[2] = MOD_IND;

  for (genvar g = 0; g < NPRE; g++) begin : g_match
    assign hit[g] = (byte_i == pre_code[g]);
  end

  always_comb begin
    pre_mod_o = MOD_NONE;
    for (int k = NPRE - 1; k >= 0; k--) begin
      if (hit[k]) pre_mod_o = pre_kind[k];
    end
  end

  assign is_pre_o = |hit;
  assign legal_o  = LEGAL_MAP[byte_i];

endmodule

// File: rtl/pfx_mode_resolve.sv
module pfx_mode_resolve
  import pfx_dec_pkg::*;
#(
  parameter logic [COL_N*LEN_W-1:0] BASE_LEN   = default_base_len(),
  parameter logic [COL_N-1:0]       YSWAP_COLS = 16'hE0E0,
  parameter logic [COL_N-1:0]       IND_COLS   = 16'h780B,
  parameter logic [COL_N-1:0]       INDY_COLS  = 16'h6000,
  parameter logic [COL_N-1:0]       SHORT_COLS = 16'h3000
) (
  input  logic [3:0]       col_i,
  input  addr_mod_e        pend_i,
  output addr_mod_e        mod_o,
  output logic [LEN_W-1:0] len_o
);

  logic [LEN_W-1:0] base_len;
  logic [5:0]       base_idx;

  assign base_idx = {1'b0, col_i, 1'b0};
  assign base_len = BASE_LEN[base_idx +: LEN_W];

  always_comb begin
    mod_o = MOD_NONE;
    len_o = base_len;
    unique case (pend_i)
      MOD_YSWAP: begin
        if (YSWAP_COLS[col_i]) mod_o = MOD_YSWAP;
      end
      MOD_IND: begin
        if (IND_COLS[col_i]) begin
          mod_o = MOD_IND;
          if (SHORT_COLS[col_i]) len_o = LEN_W'(1);
        end
      end
      MOD_INDY: begin
        if (INDY_COLS[col_i]) begin
          mod_o = MOD_INDY;
          len_o = LEN_W'(1);
        end
      end
      default: begin
        mod_o = MOD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/pfx_dec_seq.sv
module pfx_dec_seq
  import pfx_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_byte,
  input  logic             is_pre,
  input  addr_mod_e        pre_mod,
  input  logic             legal,
  input  addr_mod_e        res_mod,
  input  logic [LEN_W-1:0] res_len,
  output addr_mod_e        pend_mod,
  output logic             dec_valid,
  output logic [OPC_W-1:0] dec_opcode,
  output addr_mod_e        dec_mod,
  output logic [LEN_W-1:0] dec_len,
  output logic             trap_req
);

  dec_state_e       state_q, state_d;
  addr_mod_e        pend_q, pend_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             dv_d, trap_d;
  logic             opc_slot;
  logic             seq_en;
  logic             out_en;

  assign pend_mod = pend_q;
  assign opc_slot = (state_q == ST_PRE) || (state_q == ST_START && !is_pre);

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    dv_d    = 1'b0;
    trap_d  = 1'b0;
    if (in_valid) begin
      if (state_q == ST_OPND) begin
        cnt_d = cnt_q - LEN_W'(1);
        if (cnt_q == LEN_W'(1)) state_d = ST_START;
      end else if (!opc_slot) begin
        pend_d  = pre_mod;
        state_d = ST_PRE;
      end else begin
        pend_d = MOD_NONE;
        if (legal) begin
          dv_d = 1'b1;
          if (res_len != '0) begin
            cnt_d   = res_len;
            state_d = ST_OPND;
          end else begin
            state_d = ST_START;
          end
        end else begin
          trap_d  = 1'b1;
          state_d = ST_START;
        end
      end
    end
  end

  assign seq_en = in_valid;
  assign out_en = dv_d;

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      pend_q  <= MOD_NONE;
      cnt_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  // pulse outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      dec_valid <= dv_d;
      trap_req  <= trap_d;
    end
  end

  // decode payload, loaded only on a decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_opcode <= '0;
      dec_mod    <= MOD_NONE;
      dec_len    <= '0;
    end else if (out_en) begin
      dec_opcode <= in_byte;
      dec_mod    <= res_mod;
      dec_len    <= res_len;
    end
  end

endmodule

// File: rtl/pfx_op_decoder.sv
module pfx_op_decoder
  import pfx_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0]       PRE_YSWAP  = 8'h90,
  parameter logic [OPC_W-1:0]       PRE_INDY   = 8'h91,
  parameter logic [OPC_W-1:0]       PRE_IND    = 8'h92,
  parameter logic [OPC_N-1:0]       LEGAL_MAP  = default_legal_map(),
  parameter logic [COL_N*LEN_W-1:0] BASE_LEN   = default_base_len(),
  parameter logic [COL_N-1:0]       YSWAP_COLS = 16'hE0E0,
  parameter logic [COL_N-1:0]       IND_COLS   = 16'h780B,
  parameter logic [COL_N-1:0]       INDY_COLS  = 16'h6000,
  parameter logic [COL_N-1:0]       SHORT_COLS = 16'h3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       dec_valid,
  output logic [7:0] dec_opcode,
  output logic [1:0] dec_mod,
  output logic [1:0] dec_len,
  output logic       trap_req
);

  logic             is_pre;
  logic             legal;
  addr_mod_e        pre_mod;
  addr_mod_e        pend_mod;
  addr_mod_e        res_mod;
  addr_mod_e        out_mod;
  logic [LEN_W-1:0] res_len;

  pfx_byte_class #(
    .PRE_YSWAP (PRE_YSWAP),
    .PRE_INDY  (PRE_INDY),
    .PRE_IND   (PRE_IND),
    .LEGAL_MAP (LEGAL_MAP)
  ) u_class (
    .byte_i    (in_byte),
    .is_pre_o  (is_pre),
    .pre_mod_o (pre_mod),
    .legal_o   (legal)
  );

  pfx_mode_resolve #(
    .BASE_LEN   (BASE_LEN),
    .YSWAP_COLS (YSWAP_COLS),
    .IND_COLS   (IND_COLS),
    .INDY_COLS  (INDY_COLS),
    .SHORT_COLS (SHORT_COLS)
  ) u_resolve (
    .col_i  (in_byte[7:4]),
    .pend_i (pend_mod),
    .mod_o  (res_mod),
    .len_o  (res_len)
  );

  pfx_dec_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .is_pre     (is_pre),
    .pre_mod    (pre_mod),
    .legal      (legal),
    .res_mod    (res_mod),
    .res_len    (res_len),
    .pend_mod   (pend_mod),
    .dec_valid  (dec_valid),
    .dec_opcode (dec_opcode),
    .dec_mod    (out_mod),
    .dec_len    (dec_len),
    .trap_req   (trap_req)
  );

  assign dec_mod = out_mod;

endmodule

// File: rtl/pfx_dec_checker.sv
module pfx_dec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       dec_valid,
  input logic [1:0] dec_mod,
  input logic [1:0] dec_len,
  input logic       trap_req
);

  // R7: a trap never coincides with a decode
  a_r7_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !dec_valid);

  // R7 / R10: a trap follows an accepted byte
  a_r7_trap_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(in_valid));

  // R10: a decode follows an accepted byte
  a_r10_dec_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

  // R5: indirect-Y forms always carry one operand byte
  a_r5_indy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_mod == 2'd3) |-> dec_len == 2'd1);

  // R2: operand count never exceeds two
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_len <= 2'd2);

  // R9: the byte after an opcode with operands is an operand
  a_r9_operand_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_len != 2'd0) |=> (!dec_valid && !trap_req));

endmodule

bind pfx_op_decoder pfx_dec_checker u_chk (.*);

// File: tb/sim_pfx_op_decoder.sv
`timescale 1ns/1ps
module sim_pfx_op_decoder;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       dec_valid;
  logic [7:0] dec_opcode;
  logic [1:0] dec_mod;
  logic [1:0] dec_len;
  logic       trap_req;

  int checks;
  int fails;
  bit done;

  typedef struct {
    bit         is_trap;
    logic [7:0] op;
    logic [1:0] md;
    logic [1:0] ln;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  pfx_op_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .dec_valid  (dec_valid),
    .dec_opcode (dec_opcode),
    .dec_mod    (dec_mod),
    .dec_len    (dec_len),
    .trap_req   (trap_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  function automatic bit ref_legal(logic [7:0] b);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = b[7:4];
    lo = b[3:0];
    if (hi >= 4'h3 && hi <= 4'h7 && (lo == 4'h1 || lo == 4'h5 || lo == 4'hB)) return 1'b0;
    if ((hi == 4'h8 || hi == 4'h9) && (lo == 4'h2 || lo == 4'h5)) return 1'b0;
    if (b == 8'h90 || b == 8'h91 || b == 8'hA7) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [1:0] ref_base(logic [3:0] c);
    case (c)
      4'h0, 4'hC, 4'hD:                      return 2'd2;
      4'h1, 4'h2, 4'h3, 4'h6, 4'hA, 4'hB, 4'hE: return 2'd1;
      default:                               return 2'd0;
    endcase
  endfunction

  function automatic exp_t ref_item(bit has_pre, logic [7:0] pre, logic [7:0] op);
    exp_t e;
    logic [3:0] c;
    c = op[7:4];
    e.op = op;
    e.md = 2'd0;
    e.ln = ref_base(c);
    e.is_trap = !ref_legal(op);
    e.tag = has_pre ? "R6" : "R2";
    if (e.is_trap) begin
      e.tag = (has_pre && (op == 8'h90 || op == 8'h91 || op == 8'h92)) ? "R8" : "R7";
    end else if (has_pre) begin
      if (pre == 8'h90 && (c == 4'h5 || c == 4'h6 || c == 4'h7 ||
                           c == 4'hD || c == 4'hE || c == 4'hF)) begin
        e.md = 2'd1; e.tag = "R3";
      end else if (pre == 8'h92 && (c == 4'h0 || c == 4'h1 || c == 4'h3 ||
                                    c == 4'hB || c == 4'hC || c == 4'hD || c == 4'hE)) begin
        e.md = 2'd2; e.tag = "R4";
        if (c == 4'hC || c == 4'hD) e.ln = 2'd1;
      end else if (pre == 8'h91 && (c == 4'hD || c == 4'hE)) begin
        e.md = 2'd3; e.ln = 2'd1; e.tag = "R5";
      end
    end
    return e;
  endfunction

  // ---------------- driver ----------------
  task automatic put(logic [7:0] b, bit v);
    @(negedge clk);
    in_valid = v;
    in_byte  = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(8'h85, 1'b0);
  endtask

  task automatic run_instr(bit has_pre, logic [7:0] pre, logic [7:0] op,
                           logic [7:0] fill, bit gap);
    exp_t e;
    e = ref_item(has_pre, pre, op);
    if (has_pre) begin
      put(pre, 1'b1);
      if (gap) put(8'h85, 1'b0);
    end
    exp_q.push_back(e);
    put(op, 1'b1);
    if (!e.is_trap) begin
      for (int i = 0; i < int'(e.ln); i++) begin
        if (gap) put(8'h91, 1'b0);
        put(fill, 1'b1);
      end
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && (dec_valid || trap_req)) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9/R10 unexpected output dv=%0b trap=%0b op=%h, expected none",
                   dec_valid, trap_req, dec_opcode);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_trap) begin
            if (!trap_req || dec_valid) begin
              fails++;
              $display("FAIL %s op=%h: got dv=%0b trap=%0b, expected trap only",
                       e.tag, e.op, dec_valid, trap_req);
            end
          end else begin
            if (!dec_valid || trap_req || dec_opcode !== e.op ||
                dec_mod !== e.md || dec_len !== e.ln) begin
              fails++;
              $display("FAIL %s: got dv=%0b trap=%0b op=%h mod=%0d len=%0d, expected op=%h mod=%0d len=%0d",
                       e.tag, dec_valid, trap_req, dec_opcode, dec_mod, dec_len,
                       e.op, e.md, e.ln);
            end
          end
        end
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(dec_valid === 1'b0, $sformatf("R1 reset dec_valid got %0b expected 0", dec_valid));
    chk(trap_req === 1'b0, $sformatf("R1 reset trap_req got %0b expected 0", trap_req));
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R7: every byte in opcode slot without prefix; R9: fill is illegal
    for (int b = 0; b < 256; b++) begin
      if (b < 8'h90 || b > 8'h92) run_instr(1'b0, 8'h00, 8'(b), 8'h85, 1'b0);
    end
    idle(2);

    // R3 / R4 / R5 / R6 / R8: every byte after each prefix; fill is a prefix value
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 256; b++) begin
        run_instr(1'b1, 8'h90 + 8'(p), 8'(b), 8'h90, 1'b0);
      end
    end
    idle(2);

    // R10: idle gaps carrying junk between every byte
    run_instr(1'b1, 8'h92, 8'hC6, 8'h92, 1'b1);
    run_instr(1'b1, 8'h91, 8'hD3, 8'h85, 1'b1);
    run_instr(1'b0, 8'h00, 8'h0A, 8'h31, 1'b1);
    run_instr(1'b1, 8'h90, 8'hF0, 8'h00, 1'b1);
    idle(2);

    // R9: long-direct opcode with operands that look like prefix and illegal bytes
    run_instr(1'b0, 8'h00, 8'hC1, 8'h92, 1'b0);
    run_instr(1'b0, 8'h00, 8'h66, 8'h85, 1'b0);

    // R11: trap while a prefix is pending, then a plain X-indexed opcode
    run_instr(1'b1, 8'h90, 8'h75, 8'h00, 1'b0);
    run_instr(1'b0, 8'h00, 8'h6E, 8'h00, 1'b0);
    idle(2);

    // R1: reset while a prefix is pending drops it
    put(8'h90, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    chk(dec_valid === 1'b0 && trap_req === 1'b0,
        $sformatf("R1 mid-run reset outputs dv=%0b trap=%0b expected 0/0", dec_valid, trap_req));
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(1'b0, 8'h00, 8'h6E, 8'h00, 1'b0);
    idle(4);

    chk(exp_q.size() == 0, $sformatf("R2 pending expected outputs got %0d expected 0", exp_q.size()));
    done = 1'b1;
    summary();
    $finish;
  end

endmodule